// File: doc/BRIEF.md
# Receive Character Queue with Per-Byte Error Tags

This block buffers characters coming out of a UART receive deserializer. Each character arrives as eight data bits plus three error tags (parity error, framing error, break). The tags travel through the queue beside their byte. The host-facing side shows the oldest stored byte on a holding-register read port. Next to it sits a status word whose error field describes that byte alone. When the host reads, the next byte and its own tags replace the old ones in the same step.

A mode input picks between a 64-deep queue and a single-slot holding register. Both modes use the same ports. The block also provides a fill level for trigger logic, a data-ready bit, a receive interrupt and a sticky overrun flag. A byte that arrives with no room is dropped, and the stored bytes stay as they were.

Top module: `rx_tag_fifo`

## Requirements
- R1: After reset `rd_data` is 0, `stat` is 0, `level` is 0 and `irq` is 0.
- R2: With `fifo_en` high, `rd_data` shows the oldest stored byte, and bytes leave in arrival order.
- R3: `stat[2]` is the parity tag, `stat[3]` the framing tag and `stat[4]` the break tag of the head byte. They are taken from `wr_tags[0]`, `wr_tags[1]` and `wr_tags[2]`, and all three read 0 while the queue is empty.
- R4: A read (`rd_en`) of a non-empty queue takes effect at the clock edge. The outputs that follow that edge show the next byte and its tags, or the empty state.
- R5: A write while `level` equals the active capacity (64 with `fifo_en` high), with no read in the same cycle, is dropped. It sets the overrun bit `stat[1]` and leaves the stored bytes and `level` unchanged.
- R6: The overrun bit is cleared by `stat_rd` unless a new overrun occurs in that same cycle.
- R7: The data-ready bit `stat[0]` and `irq` are high exactly when `level` is non-zero.
- R8: `level` gives the number of stored bytes, from 0 up to 64.
- R9: A read while empty leaves `rd_data` at its last value, keeps `level` at 0 and reports no tags.
- R10: With `fifo_en` low the block holds at most one byte, so a second write before a read overruns.
- R11: A change of `fifo_en` from its value in the previous cycle empties the queue, and a write in that cycle is discarded. The previous value is taken as 1 after reset.
- R12: When the queue is full, a write together with a read in the same cycle is accepted and `level` stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1: 64-deep queue, 0: single holding slot |
| wr_valid | input | 1 | Character from the deserializer this cycle |
| wr_data | input | 8 | Received byte |
| wr_tags | input | 3 | {break, framing, parity} tags of the byte |
| rd_en | input | 1 | Host read of the holding register (pop) |
| stat_rd | input | 1 | Host read of status, clears overrun |
| rd_data | output | 8 | Head byte (last value when empty) |
| stat | output | 5 | {break, framing, parity, overrun, data ready} |
| level | output | 7 | Number of stored bytes |
| irq | output | 1 | Receive data available interrupt |

## Verification
Directed sequences cover the following:
- bytes carrying distinct tag patterns, which separates ordering errors from tag misalignment;
- filling to exactly 64 and writing once more, which tells dropping apart from overwriting;
- a simultaneous read and write at full, which separates a correct capacity test from an off-by-one;
- reads on an empty queue, which show the last byte is held.

Mode switches check the flush and the single-slot limit. A long seeded random mix of writes, reads, status reads and occasional mode changes then compares every output each cycle against a queue model. This exposes pointer wrap and bypass faults that the directed cases miss.

// File: rtl/rx_tag_fifo_pkg.sv
package rx_tag_fifo_pkg;
  localparam int TAG_W = 3;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_tag_t;
endpackage

// File: rtl/rx_tag_store.sv
module rx_tag_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int ENT_W = DATA_W + rx_tag_fifo_pkg::TAG_W,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             one_slot,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic [ENT_W-1:0] push_ent,
  output logic [CW-1:0]    count_n,
  output logic [ENT_W-1:0] head_n,
  output logic             drop
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr, wr_ptr_n, rd_ptr_n;
  logic [CW-1:0]    count, limit;
  logic             accept, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    limit    = one_slot ? CW'(1) : CW'(DEPTH);
    pop_ok   = pop_req && (count != '0) && !flush;
    accept   = push_req && !flush && ((count < limit) || pop_ok);
    drop     = push_req && !flush && !accept;
    wr_ptr_n = flush ? '0 : (accept ? ptr_inc(wr_ptr) : wr_ptr);
    rd_ptr_n = flush ? '0 : (pop_ok ? ptr_inc(rd_ptr) : rd_ptr);
    if (flush)
      count_n = '0;
    else
      count_n = count + CW'(accept) - CW'(pop_ok);
    if (accept && (rd_ptr_n == wr_ptr))
      head_n = push_ent;
    else
      head_n = mem[rd_ptr_n];
  end

  always_ff @(posedge clk) begin
    if (accept)
      mem[wr_ptr] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      count  <= count_n;
    end
  end
endmodule

// File: rtl/rx_tag_head.sv
module rx_tag_head #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int ENT_W = DATA_W + rx_tag_fifo_pkg::TAG_W,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     count_n,
  input  logic [ENT_W-1:0]  head_n,
  input  logic              drop,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic [4:0]        stat,
  output logic [CW-1:0]     level,
  output logic              irq
);
  import rx_tag_fifo_pkg::*;

  rx_tag_t tag_q;
  logic    ovr_q, rdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      tag_q   <= '0;
      ovr_q   <= 1'b0;
      rdy_q   <= 1'b0;
      level   <= '0;
      irq     <= 1'b0;
    end else begin
      level <= count_n;
      rdy_q <= (count_n != '0);
      irq   <= (count_n != '0);
      if (count_n != '0) begin
        rd_data <= head_n[DATA_W-1:0];
        tag_q   <= head_n[ENT_W-1:DATA_W];
      end else begin
        tag_q   <= '0;
      end
      if (drop)
        ovr_q <= 1'b1;
      else if (stat_rd)
        ovr_q <= 1'b0;
    end
  end

  assign stat = {tag_q.brk, tag_q.frm, tag_q.par, ovr_q, rdy_q};
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int TW    = rx_tag_fifo_pkg::TAG_W,
  localparam int ENT_W = DATA_W + TW,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TW-1:0]     wr_tags,
  input  logic              rd_en,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic [4:0]        stat,
  output logic [CW-1:0]     level,
  output logic              irq
);
  logic             en_q, flush, drop;
  logic [CW-1:0]    count_n;
  logic [ENT_W-1:0] head_n;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b1;
    else     en_q <= fifo_en;
  end

  assign flush = (fifo_en != en_q);

  rx_tag_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .one_slot (!fifo_en),
    .push_req (wr_valid),
    .pop_req  (rd_en),
    .push_ent ({wr_tags, wr_data}),
    .count_n  (count_n),
    .head_n   (head_n),
    .drop     (drop)
  );

  rx_tag_head #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_head (
    .clk     (clk),
    .rst     (rst),
    .count_n (count_n),
    .head_n  (head_n),
    .drop    (drop),
    .stat_rd (stat_rd),
    .rd_data (rd_data),
    .stat    (stat),
    .level   (level),
    .irq     (irq)
  );
endmodule

// File: rtl/rx_tag_fifo_chk.sv
module rx_tag_fifo_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              fifo_en,
  input logic              wr_valid,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic [4:0]        stat,
  input logic [CW-1:0]     level,
  input logic              irq
);
  AST_READY_LEVEL: assert property (@(posedge clk) disable iff (rst) (stat[0] == (level != '0)) && (irq == (level != '0))); // R7
  AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (rst) level <= CW'(DEPTH)); // R8
  AST_EMPTY_TAGS: assert property (@(posedge clk) disable iff (rst) (level == '0) |-> (stat[4:2] == 3'b000)); // R3
  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (rst) (rd_en && !wr_valid && level == '0) |=> $stable(rd_data)); // R9
  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (rst) !fifo_en |=> level <= CW'(1)); // R10
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst) (fifo_en && wr_valid && !rd_en && level == CW'(DEPTH)) |=> (stat[1] && level == CW'(DEPTH))); // R5
endmodule

bind rx_tag_fifo rx_tag_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .fifo_en  (fifo_en),
  .wr_valid (wr_valid),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .stat     (stat),
  .level    (level),
  .irq      (irq)
);

// File: tb/rx_tag_fifo_bench.sv
`timescale 1ns/1ps
module rx_tag_fifo_bench;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_en = 1'b1;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic [2:0] wr_tags = '0;
  logic       rd_en = 1'b0;
  logic       stat_rd = 1'b0;
  logic [7:0] rd_data;
  logic [4:0] stat;
  logic [6:0] level;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [10:0] mq[$];
  bit          m_en = 1;
  bit          m_ovr = 0;
  logic [7:0]  m_last = '0;

  always #2.5 clk = ~clk;

  rx_tag_fifo u_rx_tag_fifo (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_tags(wr_tags), .rd_en(rd_en), .stat_rd(stat_rd),
    .rd_data(rd_data), .stat(stat), .level(level), .irq(irq)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_stat();
    logic [2:0] t;
    t = (mq.size() > 0) ? mq[0][10:8] : 3'b000;
    return {t, m_ovr, mq.size() > 0};
  endfunction

  task automatic check_all(string req);
    check(req, "rd_data", rd_data, m_last);
    check(req, "stat", stat, exp_stat());
    check(req, "level", level, mq.size());
    check(req, "irq", irq, mq.size() > 0);
  endtask

  task automatic model(bit push, logic [7:0] d, logic [2:0] t, bit pop, bit srd, bit en);
    bit flush, pop_ok, acc, ovr_set;
    int lim;
    flush = (en != m_en);
    m_en = en;
    ovr_set = 0;
    if (flush) mq.delete();
    else begin
      lim = en ? DEPTH : 1;
      pop_ok = pop && mq.size() > 0;
      acc = push && (mq.size() < lim || pop_ok);
      ovr_set = push && !acc;
      if (pop_ok) void'(mq.pop_front());
      if (acc) mq.push_back({t, d});
    end
    if (ovr_set) m_ovr = 1;
    else if (srd) m_ovr = 0;
    if (mq.size() > 0) m_last = mq[0][7:0];
  endtask

  task automatic step(bit push, logic [7:0] d, logic [2:0] t, bit pop, bit srd, bit en, string req);
    wr_valid = push; wr_data = d; wr_tags = t; rd_en = pop; stat_rd = srd; fifo_en = en;
    model(push, d, t, pop, srd, en);
    @(posedge clk); #1;
    wr_valid = 0; rd_en = 0; stat_rd = 0;
    check_all(req);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    check_all("R1");
    // R2 R3: three bytes, distinct tag patterns
    step(1, 8'hA1, 3'b001, 0, 0, 1, "R3");
    step(1, 8'hB2, 3'b010, 0, 0, 1, "R2");
    step(1, 8'hC3, 3'b100, 0, 0, 1, "R2");
    // R4: pops move head and tags immediately
    step(0, 0, 0, 1, 0, 1, "R4");
    step(0, 0, 0, 1, 0, 1, "R4");
    step(0, 0, 0, 1, 0, 1, "R4");
    // R9: read while empty
    step(0, 0, 0, 1, 0, 1, "R9");
    step(0, 0, 0, 1, 0, 1, "R9");
    // R8: fill to 64
    for (int i = 0; i < DEPTH; i++)
      step(1, 8'(i + 16), 3'(i), 0, 0, 1, "R8");
    // R5: extra write dropped
    step(1, 8'hEE, 3'b111, 0, 0, 1, "R5");
    // R12: write plus read at full
    step(1, 8'h5A, 3'b101, 1, 0, 1, "R12");
    // R6: status read clears overrun
    step(0, 0, 0, 0, 1, 1, "R6");
    // R11: mode change flushes, write discarded
    step(1, 8'h77, 3'b000, 0, 0, 0, "R11");
    // R10: single slot
    step(1, 8'h31, 3'b010, 0, 0, 0, "R10");
    step(1, 8'h32, 3'b000, 0, 0, 0, "R10");
    step(0, 0, 0, 1, 1, 0, "R10");
    step(0, 0, 0, 0, 0, 1, "R11");
    step(0, 0, 0, 0, 0, 1, "R7");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit en;
      en = m_en;
      if (($urandom % 300) == 0) en = ~m_en;
      step(($urandom % 100) < 55, 8'($urandom), 3'($urandom), ($urandom % 100) < 45,
           ($urandom % 16) == 0, en, "R2");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule